// File: doc/BRIEF.md
# Discrete-Time Cellular Network Array

This block is a grid of processing elements, one for each cell of a discrete-time cellular nonlinear network. Each element keeps its own input value `u` and state `x`. It exposes an output `y = clamp(x, -1, +1)` to its eight surrounding elements. In every iteration step all cells update at once. Each cell forms the sum of a 3×3 feedback template applied to the neighbour outputs, a 3×3 control template applied to the neighbour inputs, and a bias. It rounds and saturates that sum, and the result becomes its new state. All words are signed fixed point with `FRAC` fraction bits. The default is an 18-bit word with 2 integer bits, so +1.0 is 65536.

Software first loads the 19 template coefficients and the per-cell input and initial state through two valid/ready write streams. It then pulses `start` with an iteration count. The array runs one step per clock cycle with no traffic at its edge. `done` pulses once the last step has been stored. The result is read cell by cell through a request/response stream. A later `start` continues from the state that was left, so operations can be chained. Every write or read stream transfers on a cycle where valid and ready are both high. A producer holds its valid and payload until that happens. The response side keeps `rsp_valid` and `rsp_data` unchanged while `rsp_ready` is low, and it accepts no new request until the pending response is taken.

Top module: `cnn_array`

## Requirements
- R1: Template writes: `tpl_sel` 0..8 sets feedback tap k and 9..17 sets control tap k-9, where k = 3·(dr+1)+(dc+1) for row offset dr and column offset dc in −1..1. `tpl_sel` 18 sets the bias, which is in the same scale as the state. Any other `tpl_sel` value is accepted and has no effect.
- R2: Cell writes: `ld_idx` = row·COLS+col sets that cell's input to `ld_u` and its state to `ld_x`. The cell's output then reads back as clamp(`ld_x`) with no step run. An index of COLS·ROWS or above changes no cell.
- R3: One step sets x = sat_W((Σ A_k·y_k + Σ B_k·u_k + z·2^FRAC + 2^(FRAC−1)) >>> FRAC). The sum is formed exactly, shifted arithmetically, and saturated to the signed W-bit range.
- R4: A cell output is its state clamped to [−2^FRAC, +2^FRAC].
- R5: A neighbour position outside the grid supplies the boundary value `BND` (zero by default) as both its output and its input.
- R6: All cells update at the same clock edge from the outputs of the previous step.
- R7: After `start` is sampled while idle with count N>0, `busy` is high for exactly N cycles, one step per cycle. `done` is high for the single cycle after that. With N=0, `done` is high in the next cycle and no state changes.
- R8: While `busy` is high, `tpl_ready`, `ld_ready` and `rq_ready` are low, and a `start` pulse is ignored.
- R9: A read request returns clamp of the addressed cell's state in `rsp_data` in the next cycle, or 0 for an index past the grid. A response that is not taken stays unchanged, and `rq_ready` stays low until it is taken.
- R10: A new run starts from the states left by the previous run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tpl_valid | input | 1 | Template write valid |
| tpl_ready | output | 1 | Template write ready |
| tpl_sel | input | 5 | Coefficient selector |
| tpl_data | input | W | Coefficient value |
| ld_valid | input | 1 | Cell write valid |
| ld_ready | output | 1 | Cell write ready |
| ld_idx | input | IW | Cell index |
| ld_u | input | W | Cell input value |
| ld_x | input | W | Cell initial state |
| start | input | 1 | Run request pulse |
| iters | input | ITW | Number of steps |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| rq_valid | input | 1 | Read request valid |
| rq_ready | output | 1 | Read request ready |
| rq_idx | input | IW | Cell index to read |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response ready |
| rsp_data | output | W | Cell output value |

## Verification
The bench builds a 3×4 grid with W=18, FRAC=16 and an 8-bit count. In that grid ten cells touch an edge and two are fully interior, so every combination of a missing row or column neighbour is exercised next to ordinary interior updates. With only 12 cells, each result can be read back in full after every run. Four-bit indices leave 12..15 free, so writes and reads past the grid can be tested. A seeded generator picks state values up to ±1.75 and mixed-sign coefficients. This pushes sums past ±1 and past the 18-bit range, so clamping, saturation and round-half-up all occur.

// File: rtl/cnn_pkg.sv
package cnn_pkg;
  localparam int NTAP  = 9;
  localparam int SEL_B = 9;
  localparam int SEL_Z = 18;
  localparam int SELW  = 5;

  typedef enum logic {ST_IDLE, ST_RUN} run_st_t;
endpackage

// File: rtl/cnn_ctrl.sv
module cnn_ctrl import cnn_pkg::*; #(
  parameter int ITW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [ITW-1:0] iters,
  output logic           busy,
  output logic           step,
  output logic           done
);
  run_st_t        st_q;
  logic [ITW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      left_q <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start) begin
          if (iters == '0) done <= 1'b1;
          else begin
            st_q   <= ST_RUN;
            left_q <= iters;
          end
        end
        ST_RUN: begin
          left_q <= left_q - 1'b1;
          if (left_q == ITW'(1)) begin
            st_q <= ST_IDLE;
            done <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = (st_q == ST_RUN);
  assign step = busy;

  // R7
  run_end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: rtl/cnn_pe.sv
module cnn_pe import cnn_pkg::*; #(
  parameter int W    = 18,
  parameter int FRAC = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ld_en,
  input  logic signed [W-1:0] ld_u,
  input  logic signed [W-1:0] ld_x,
  input  logic                step,
  input  logic signed [W-1:0] a_t  [NTAP],
  input  logic signed [W-1:0] b_t  [NTAP],
  input  logic signed [W-1:0] bias,
  input  logic signed [W-1:0] y_nb [NTAP],
  input  logic signed [W-1:0] u_nb [NTAP],
  output logic signed [W-1:0] u_q,
  output logic signed [W-1:0] y_o
);
  localparam int PW  = 2 * W;
  localparam int ACC = 2 * W + 5;
  localparam logic signed [ACC-1:0] HALF = ACC'(1) <<< (FRAC - 1);
  localparam logic signed [ACC-1:0] MAXV = {{(ACC-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [ACC-1:0] MINV = ~MAXV;
  localparam logic signed [W-1:0]   ONE  = W'(1) <<< FRAC;
  localparam logic signed [W-1:0]   NONE = -ONE;

  logic signed [W-1:0]   x_q, x_nx;
  logic signed [PW-1:0]  pa [NTAP];
  logic signed [PW-1:0]  pb [NTAP];
  logic signed [ACC-1:0] acc, rnd;

  always_comb begin
    acc = ACC'(bias) <<< FRAC;
    for (int k = 0; k < NTAP; k++) begin
      pa[k] = PW'(a_t[k]) * PW'(y_nb[k]);
      pb[k] = PW'(b_t[k]) * PW'(u_nb[k]);
      acc   = acc + ACC'(pa[k]) + ACC'(pb[k]);
    end
    rnd = (acc + HALF) >>> FRAC;
    if (rnd > MAXV)      x_nx = MAXV[W-1:0];
    else if (rnd < MINV) x_nx = MINV[W-1:0];
    else                 x_nx = rnd[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      u_q <= '0;
    end else if (ld_en) begin
      x_q <= ld_x;
      u_q <= ld_u;
    end else if (step) begin
      x_q <= x_nx;
    end
  end

  assign y_o = (x_q > ONE) ? ONE : (x_q < NONE) ? NONE : x_q;

  // R10
  state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !ld_en) |=> $stable(x_q));
endmodule

// File: rtl/cnn_array.sv
module cnn_array import cnn_pkg::*; #(
  parameter int ROWS = 8,
  parameter int COLS = 16,
  parameter int W    = 18,
  parameter int FRAC = 16,
  parameter int ITW  = 16,
  parameter logic signed [W-1:0] BND = '0,
  localparam int NCELL = ROWS * COLS,
  localparam int IW    = (NCELL > 2) ? $clog2(NCELL) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tpl_valid,
  output logic                tpl_ready,
  input  logic [SELW-1:0]     tpl_sel,
  input  logic signed [W-1:0] tpl_data,
  input  logic                ld_valid,
  output logic                ld_ready,
  input  logic [IW-1:0]       ld_idx,
  input  logic signed [W-1:0] ld_u,
  input  logic signed [W-1:0] ld_x,
  input  logic                start,
  input  logic [ITW-1:0]      iters,
  output logic                busy,
  output logic                done,
  input  logic                rq_valid,
  output logic                rq_ready,
  input  logic [IW-1:0]       rq_idx,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic signed [W-1:0] rsp_data
);
  logic signed [W-1:0] a_q [NTAP];
  logic signed [W-1:0] b_q [NTAP];
  logic signed [W-1:0] bias_q;
  logic signed [W-1:0] y_all [NCELL];
  logic signed [W-1:0] u_all [NCELL];
  logic step, tpl_fire, ld_fire, rq_fire;

  cnn_ctrl #(.ITW(ITW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .iters(iters),
    .busy(busy), .step(step), .done(done)
  );

  assign tpl_ready = !busy;
  assign ld_ready  = !busy;
  assign rq_ready  = !busy && (!rsp_valid || rsp_ready);
  assign tpl_fire  = tpl_valid && tpl_ready;
  assign ld_fire   = ld_valid && ld_ready;
  assign rq_fire   = rq_valid && rq_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NTAP; k++) begin
        a_q[k] <= '0;
        b_q[k] <= '0;
      end
      bias_q <= '0;
    end else if (tpl_fire) begin
      for (int k = 0; k < NTAP; k++) begin
        if (tpl_sel == SELW'(k))         a_q[k] <= tpl_data;
        if (tpl_sel == SELW'(k + SEL_B)) b_q[k] <= tpl_data;
      end
      if (tpl_sel == SELW'(SEL_Z)) bias_q <= tpl_data;
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int I = r * COLS + c;
      logic signed [W-1:0] ynb [NTAP];
      logic signed [W-1:0] unb [NTAP];
      for (genvar k = 0; k < NTAP; k++) begin : g_tap
        localparam int RR = r + k / 3 - 1;
        localparam int CC = c + k % 3 - 1;
        if (RR >= 0 && RR < ROWS && CC >= 0 && CC < COLS) begin : g_in
          assign ynb[k] = y_all[RR * COLS + CC];
          assign unb[k] = u_all[RR * COLS + CC];
        end else begin : g_edge
          assign ynb[k] = BND;
          assign unb[k] = BND;
        end
      end
      cnn_pe #(.W(W), .FRAC(FRAC)) u_pe (
        .clk(clk), .rst_n(rst_n),
        .ld_en(ld_fire && (ld_idx == IW'(I))),
        .ld_u(ld_u), .ld_x(ld_x), .step(step),
        .a_t(a_q), .b_t(b_q), .bias(bias_q),
        .y_nb(ynb), .u_nb(unb),
        .u_q(u_all[I]), .y_o(y_all[I])
      );
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (rq_fire) begin
      rsp_valid <= 1'b1;
      rsp_data  <= ({1'b0, rq_idx} < (IW+1)'(NCELL)) ? y_all[rq_idx] : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
  // R8
  tpl_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(bias_q));
endmodule

// File: tb/sim_cnn_array.sv
module sim_cnn_array;
  localparam int ROWS = 3, COLS = 4, W = 18, FRAC = 16, ITW = 8;
  localparam int NC = ROWS * COLS, IW = 4;
  localparam longint ONE = 65536, XMAX = 131071, XMIN = -131072;

  logic clk = 0, rst_n = 0;
  logic tpl_valid = 0, ld_valid = 0, start = 0, rq_valid = 0, rsp_ready = 1;
  logic [4:0] tpl_sel = 0;
  logic signed [W-1:0] tpl_data = 0, ld_u = 0, ld_x = 0;
  logic [IW-1:0] ld_idx = 0, rq_idx = 0;
  logic [ITW-1:0] iters = 0;
  logic tpl_ready, ld_ready, busy, done, rq_ready, rsp_valid;
  logic signed [W-1:0] rsp_data;

  always #2.5 clk = ~clk;

  cnn_array #(.ROWS(ROWS), .COLS(COLS), .W(W), .FRAC(FRAC), .ITW(ITW)) u0 (
    .clk(clk), .rst_n(rst_n), .tpl_valid(tpl_valid), .tpl_ready(tpl_ready),
    .tpl_sel(tpl_sel), .tpl_data(tpl_data), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_idx(ld_idx), .ld_u(ld_u), .ld_x(ld_x), .start(start), .iters(iters),
    .busy(busy), .done(done), .rq_valid(rq_valid), .rq_ready(rq_ready),
    .rq_idx(rq_idx), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  int checks = 0, fails = 0, cyc = 0;
  longint ma [9], mb [9], mz;
  longint mx [NC], mu [NC];
  int unsigned seed = 32'h1234_5678;

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic longint rnd(longint span);
    seed = seed * 32'd1103515245 + 32'd12345;
    return longint'(seed >> 8) % (2 * span + 1) - span;
  endfunction

  function automatic longint clampy(longint v);
    return (v > ONE) ? ONE : (v < -ONE) ? -ONE : v;
  endfunction

  function automatic longint nb_y(int r, int c);
    if (r < 0 || r >= ROWS || c < 0 || c >= COLS) return 0;
    return clampy(mx[r * COLS + c]);
  endfunction

  function automatic longint nb_u(int r, int c);
    if (r < 0 || r >= ROWS || c < 0 || c >= COLS) return 0;
    return mu[r * COLS + c];
  endfunction

  task automatic model_step();
    longint nx [NC];
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        longint s = mz * ONE;
        for (int k = 0; k < 9; k++)
          s += ma[k] * nb_y(r + k / 3 - 1, c + k % 3 - 1)
             + mb[k] * nb_u(r + k / 3 - 1, c + k % 3 - 1);
        s = (s + 32768) >>> 16;
        nx[r * COLS + c] = (s > XMAX) ? XMAX : (s < XMIN) ? XMIN : s;
      end
    for (int i = 0; i < NC; i++) mx[i] = nx[i];
  endtask

  task automatic put_tpl(int sel, longint v);
    @(negedge clk);
    chk("R1 tpl_ready idle", tpl_ready, 1);
    tpl_valid = 1; tpl_sel = 5'(sel); tpl_data = W'(v);
    @(posedge clk); #1 tpl_valid = 0;
    if (sel < 9) ma[sel] = v;
    else if (sel < 18) mb[sel - 9] = v;
    else if (sel == 18) mz = v;
  endtask

  task automatic put_cell(int idx, longint u, longint x);
    @(negedge clk);
    ld_valid = 1; ld_idx = IW'(idx); ld_u = W'(u); ld_x = W'(x);
    @(posedge clk); #1 ld_valid = 0;
    if (idx < NC) begin mu[idx] = u; mx[idx] = x; end
  endtask

  task automatic read_cell(string req, int idx);
    @(negedge clk);
    rq_valid = 1; rq_idx = IW'(idx); rsp_ready = 1;
    @(posedge clk);
    @(negedge clk); rq_valid = 0;
    chk({req, " rsp_valid"}, rsp_valid, 1);
    chk({req, " rsp_data"}, rsp_data, (idx < NC) ? clampy(mx[idx]) : 0);
  endtask

  task automatic read_all(string req);
    for (int i = 0; i < NC; i++) read_cell(req, i);
  endtask

  task automatic run(int n, bit poke);
    @(negedge clk); start = 1; iters = ITW'(n);
    @(posedge clk); #1 start = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R7 busy during run", busy, 1);
      chk("R7 no early done", done, 0);
      chk("R8 ld_ready low", ld_ready, 0);
      chk("R8 rq_ready low", rq_ready, 0);
      if (poke && i == 0) begin
        start = 1; iters = 8'd7;
        tpl_valid = 1; tpl_sel = 5'd18; tpl_data = 18'sd12345;
        ld_valid = 1; ld_idx = 0; ld_u = 18'sd777; ld_x = 18'sd777;
      end else begin
        start = 0; tpl_valid = 0; ld_valid = 0;
      end
      model_step();
      @(posedge clk);
    end
    @(negedge clk);
    start = 0; tpl_valid = 0; ld_valid = 0;
    chk("R7 busy low after run", busy, 0);
    chk("R7 done pulse", done, 1);
    @(negedge clk);
    chk("R7 done one cycle", done, 0);
  endtask

  initial begin
    for (int k = 0; k < 9; k++) begin ma[k] = 0; mb[k] = 0; end
    mz = 0;
    for (int i = 0; i < NC; i++) begin mx[i] = 0; mu[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R7 reset busy", busy, 0);
    chk("R7 reset done", done, 0);
    chk("R9 reset rsp_valid", rsp_valid, 0);
    read_cell("R9 reset cell", 0);

    // R2: load and read back clamped state without running
    for (int i = 0; i < NC; i++) put_cell(i, rnd(114688), rnd(114688));
    put_cell(13, 5000, 5000);
    read_all("R2 load");
    read_cell("R9 out-of-grid read", 14);

    // R1: templates, with an unused selector
    for (int k = 0; k < 9; k++) put_tpl(k, rnd(24000));
    put_tpl(4, 98304);
    for (int k = 0; k < 9; k++) put_tpl(9 + k, rnd(20000));
    put_tpl(18, -9000);
    put_tpl(25, 99999);

    // R3 R4 R5 R6: several steps compared cell by cell
    run(1, 0); read_all("R3 R5 R6 one step");
    run(3, 0); read_all("R10 chained run");
    run(0, 0); read_all("R7 zero-count run");

    // R8: start and writes ignored during a run
    run(4, 1); read_all("R8 writes ignored while busy");

    // R4: large templates drive states into saturation and clamp
    put_tpl(4, 131071); put_tpl(13, 131071); put_tpl(18, 131071);
    for (int i = 0; i < NC; i++) put_cell(i, (i % 2) ? 65536 : -65536, rnd(114688));
    run(2, 0); read_all("R4 R3 saturation");
    put_tpl(18, -131072);
    run(2, 0); read_all("R4 negative saturation");

    // R3 rounding with tiny coefficients
    for (int k = 0; k < 9; k++) begin put_tpl(k, 3 + k); put_tpl(9 + k, -(5 + k)); end
    put_tpl(18, 1);
    for (int i = 0; i < NC; i++) put_cell(i, 32768 + i, 32768 - 3 * i);
    run(1, 0); read_all("R3 rounding");

    // R9: back-pressure on the response
    @(negedge clk); rq_valid = 1; rq_idx = 4'd5; rsp_ready = 0;
    @(posedge clk);
    @(negedge clk); rq_idx = 4'd6;
    chk("R9 rq_ready low while pending", rq_ready, 0);
    chk("R9 pending data", rsp_data, clampy(mx[5]));
    @(posedge clk);
    @(negedge clk);
    chk("R9 held valid", rsp_valid, 1);
    chk("R9 held data", rsp_data, clampy(mx[5]));
    rsp_ready = 1;
    @(posedge clk);
    @(negedge clk); rq_valid = 0;
    chk("R9 next data", rsp_data, clampy(mx[6]));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule